// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block is the control sequencer that a small 8-bit processor core uses to enter its exception handlers. At each instruction boundary it looks at the pending non-maskable request, the maskable request level with the interrupt-disable flag, and a strobe saying that a break opcode was decoded. It picks one source and then runs a fixed six-step entry routine. The routine pushes the return address, high byte first, and then the status byte. It then updates the flags and reads the two vector bytes. Leaving reset runs the same routine, but the stack writes are suppressed.

The core's datapath is outside the block. The sequencer tells it which byte to put on the stack and when the stack pointer steps. It gives the bits to force into the pushed status byte and whether the pushed return address must skip the operand byte of a break. It also drives the vector address, the flag update strobes and a halt indication. Two halt opcodes are handled. The wait-for-interrupt opcode parks the sequencer until a request arrives. The stop opcode parks it until reset.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held, no stack write, pointer step or vector read is requested and halt is low. In the cycles after release, the entry routine runs with spDec high for the three push steps and stackWr low. The vector read comes from 0xFFFC then 0xFFFD.
- R2: A taken entry begins in the cycle after the deciding clock edge, and each step lasts exactly one cycle, in this order. Steps 1, 2 and 3 have stackWr=1 and spDec=1, with stackSel = 1 (return high byte), then 2 (return low byte), then 3 (status). Step 4 has setI=1 and clrD=1. Steps 5 and 6 have vecRd=1. After step 6 all request outputs are low.
- R3: The vector low and high addresses are 0xFFFA/0xFFFB for the non-maskable request and 0xFFFE/0xFFFF for both the maskable request and break.
- R4: During the status push, statusOr is 0x30 for break (bit 5 and bit 4 set) and 0x20 for either interrupt. It is 0x00 in every other cycle.
- R5: pcSkip is high during the two return-address pushes of a break entry only, so that the pushed return address passes over the byte after the opcode.
- R6: A maskable request (irqN low) is not taken at a boundary while iFlag is 1.
- R7: A falling edge on nmiN is latched and taken at the next boundary whatever the value of iFlag. The latch clears when that entry starts, so a level held low does not cause a second entry.
- R8: Priority at a boundary is non-maskable first, then maskable, then break. When an interrupt wins over a coinciding break, its entry pushes bit 4 clear with pcSkip low, so the break opcode runs again after the handler returns and is not lost.
- R9: After a wait opcode, halt stays high until irqN goes low or a non-maskable edge arrives. On irqN low with iFlag=1 it resumes without any entry. With iFlag=0 it takes the maskable entry. A non-maskable edge takes that entry.
- R10: After a stop opcode, halt stays high and every request, edge and boundary is ignored until reset, which then runs the reset entry.
- R11: Boundary and decode strobes that arrive while an entry routine is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiN | input | 1 | Non-maskable request, active low, edge-detected |
| irqN | input | 1 | Maskable request, active low, level |
| iFlag | input | 1 | Current interrupt-disable flag |
| boundary | input | 1 | Instruction boundary strobe |
| brkHit | input | 1 | Break opcode decoded at this boundary |
| waiHit | input | 1 | Wait-for-interrupt opcode decoded at this boundary |
| stpHit | input | 1 | Stop opcode decoded at this boundary |
| stackWr | output | 1 | Stack write request |
| spDec | output | 1 | Stack pointer decrement after this step |
| stackSel | output | 2 | Byte to push: 0 none, 1 return high, 2 return low, 3 status |
| pcSkip | output | 1 | Return address must skip the operand byte |
| statusOr | output | 8 | Bits forced into the pushed status byte |
| setI | output | 1 | Set the interrupt-disable flag |
| clrD | output | 1 | Clear the decimal flag |
| vecRd | output | 1 | Vector byte read request |
| vecAddr | output | 16 | Vector byte address |
| halt | output | 1 | Core halted by wait or stop |

## Verification
The assertions assume that brkHit, waiHit and stpHit come from one decoded opcode. At most one of them is high, and only together with boundary. They also assume that irqN and iFlag are stable around the clock edge, since only nmiN passes through the optional synchronizer. The bench drives every input at the falling clock edge. It raises the opcode strobes one at a time, except where the R11 case deliberately holds boundary and brkHit high during an entry. It changes nmiN only one full cycle before the boundary it should affect.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_IRQ = 2'd2,
    SRC_BRK = 2'd3
  } srcKind_e;

  typedef enum logic [3:0] {
    ST_HOLD   = 4'd0,
    ST_IDLE   = 4'd1,
    ST_PUSH_H = 4'd2,
    ST_PUSH_L = 4'd3,
    ST_PUSH_P = 4'd4,
    ST_FLAGS  = 4'd5,
    ST_VEC_L  = 4'd6,
    ST_VEC_H  = 4'd7,
    ST_WAIT   = 4'd8,
    ST_STOP   = 4'd9
  } seqState_e;

  typedef struct packed {
    logic     pushHi;
    logic     pushLo;
    logic     pushSt;
    logic     flagUpd;
    logic     vecLo;
    logic     vecHi;
    srcKind_e src;
  } seqStrobe_t;

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_PCH  = 2'd1;
  localparam logic [1:0] SEL_PCL  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter int NMI_SYNC = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiN,
  input  logic       irqN,
  input  logic       iFlag,
  input  logic       boundary,
  input  logic       brkHit,
  input  logic       waiHit,
  input  logic       stpHit,
  output seqStrobe_t strobe,
  output logic       halt
);

  logic      nmiS;
  logic      nmiPrev;
  logic      nmiPend;
  logic      nmiFall;
  logic      nmiReq;
  logic      irqReq;
  logic      takeNmi;
  seqState_e state, stateNext;
  srcKind_e  srcQ, srcNext;

  generate
    if (NMI_SYNC == 0) begin : gNoSync
      assign nmiS = nmiN;
    end else begin : gSync
      logic [NMI_SYNC-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain <= '1;
        end else begin
          chain[0] <= nmiN;
          for (int i = 1; i < NMI_SYNC; i++) chain[i] <= chain[i-1];
        end
      end
      assign nmiS = chain[NMI_SYNC-1];
    end
  endgenerate

  assign nmiFall = nmiPrev & ~nmiS;
  assign nmiReq  = nmiPend | nmiFall;
  assign irqReq  = ~irqN & ~iFlag;

  always_comb begin
    stateNext = state;
    srcNext   = srcQ;
    takeNmi   = 1'b0;
    unique case (state)
      ST_HOLD:   stateNext = ST_PUSH_H;
      ST_IDLE: begin
        if (boundary) begin
          if (nmiReq) begin
            stateNext = ST_PUSH_H;
            srcNext   = SRC_NMI;
            takeNmi   = 1'b1;
          end else if (irqReq) begin
            stateNext = ST_PUSH_H;
            srcNext   = SRC_IRQ;
          end else if (brkHit) begin
            stateNext = ST_PUSH_H;
            srcNext   = SRC_BRK;
          end else if (waiHit) begin
            stateNext = ST_WAIT;
          end else if (stpHit) begin
            stateNext = ST_STOP;
          end
        end
      end
      ST_PUSH_H: stateNext = ST_PUSH_L;
      ST_PUSH_L: stateNext = ST_PUSH_P;
      ST_PUSH_P: stateNext = ST_FLAGS;
      ST_FLAGS:  stateNext = ST_VEC_L;
      ST_VEC_L:  stateNext = ST_VEC_H;
      ST_VEC_H:  stateNext = ST_IDLE;
      ST_WAIT: begin
        if (nmiReq) begin
          stateNext = ST_PUSH_H;
          srcNext   = SRC_NMI;
          takeNmi   = 1'b1;
        end else if (!irqN) begin
          if (iFlag) begin
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_PUSH_H;
            srcNext   = SRC_IRQ;
          end
        end
      end
      ST_STOP:   stateNext = ST_STOP;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HOLD;
      srcQ    <= SRC_RST;
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
    end else begin
      state   <= stateNext;
      srcQ    <= srcNext;
      nmiPrev <= nmiS;
      nmiPend <= nmiReq & ~takeNmi;
    end
  end

  always_comb begin
    strobe.pushHi  = (state == ST_PUSH_H);
    strobe.pushLo  = (state == ST_PUSH_L);
    strobe.pushSt  = (state == ST_PUSH_P);
    strobe.flagUpd = (state == ST_FLAGS);
    strobe.vecLo   = (state == ST_VEC_L);
    strobe.vecHi   = (state == ST_VEC_H);
    strobe.src     = srcQ;
  end

  assign halt = (state == ST_WAIT) || (state == ST_STOP);

  // R10: stop is only left through reset
  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_STOP |=> state == ST_STOP);

  // R2: the high-byte push is always followed by the low-byte push
  a_r2_push_order: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PUSH_H |=> state == ST_PUSH_L);

  // R8: a latched non-maskable request wins at a boundary
  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && boundary && nmiPend) |=> (state == ST_PUSH_H && srcQ == SRC_NMI));

  // R6: a masked level with nothing else pending leaves the sequencer idle
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && boundary && !nmiReq && iFlag && !brkHit && !waiHit && !stpHit)
    |=> state == ST_IDLE);

  // R9: wait holds while no request is present
  a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && irqN && !nmiReq) |=> state == ST_WAIT);

  // R11: the running routine cannot be restarted by a boundary
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PUSH_L && boundary) |=> state == ST_PUSH_P);

endmodule

// File: rtl/irqseq_dp.sv
module irqseq_dp
  import irqseq_pkg::*;
#(
  parameter int          VEC_W   = 16,
  parameter int          ST_W    = 8,
  parameter int          B_POS   = 4,
  parameter int          U_POS   = 5,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  output logic             stackWr,
  output logic             spDec,
  output logic [1:0]       stackSel,
  output logic             pcSkip,
  output logic [ST_W-1:0]  statusOr,
  output logic             setI,
  output logic             clrD,
  output logic             vecRd,
  output logic [VEC_W-1:0] vecAddr
);

  localparam logic [ST_W-1:0] U_MASK = ST_W'(1) << U_POS;
  localparam logic [ST_W-1:0] B_MASK = ST_W'(1) << B_POS;

  logic             anyPush;
  logic             isBrk;
  logic [VEC_W-1:0] vecBase;

  assign anyPush = strobe.pushHi | strobe.pushLo | strobe.pushSt;
  assign isBrk   = (strobe.src == SRC_BRK);

  always_comb begin
    unique case (strobe.src)
      SRC_NMI: vecBase = VEC_W'(NMI_VEC);
      SRC_RST: vecBase = VEC_W'(RST_VEC);
      default: vecBase = VEC_W'(IRQ_VEC);
    endcase
  end

  always_comb begin
    if (strobe.pushHi)      stackSel = SEL_PCH;
    else if (strobe.pushLo) stackSel = SEL_PCL;
    else if (strobe.pushSt) stackSel = SEL_STAT;
    else                    stackSel = SEL_NONE;
  end

  assign stackWr  = anyPush & (strobe.src != SRC_RST);
  assign spDec    = anyPush;
  assign pcSkip   = (strobe.pushHi | strobe.pushLo) & isBrk;
  assign statusOr = strobe.pushSt ? (U_MASK | (isBrk ? B_MASK : '0)) : '0;
  assign setI     = strobe.flagUpd;
  assign clrD     = strobe.flagUpd;
  assign vecRd    = strobe.vecLo | strobe.vecHi;

  always_comb begin
    if (strobe.vecLo)      vecAddr = vecBase;
    else if (strobe.vecHi) vecAddr = vecBase + VEC_W'(1);
    else                   vecAddr = '0;
  end

  // R1: the reset routine never writes the stack
  a_r1_reset_silent: assert property (@(posedge clk) disable iff (!rstN)
    strobe.src == SRC_RST |-> !stackWr);

  // R2: at most one step of the routine is active in any cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pushHi, strobe.pushLo, strobe.pushSt, strobe.flagUpd, strobe.vecLo, strobe.vecHi}));

  // R4: a pushed status byte always carries the unused bit
  a_r4_u_bit: assert property (@(posedge clk) disable iff (!rstN)
    stackSel == SEL_STAT |-> statusOr[U_POS]);

  // R5: skipping the operand byte belongs to break entries alone
  a_r5_skip_brk: assert property (@(posedge clk) disable iff (!rstN)
    pcSkip |-> (isBrk && stackWr));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter int          NMI_SYNC = 0,
  parameter int          VEC_W    = 16,
  parameter int          ST_W     = 8,
  parameter int          B_POS    = 4,
  parameter int          U_POS    = 5,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [15:0] RST_VEC  = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiN,
  input  logic             irqN,
  input  logic             iFlag,
  input  logic             boundary,
  input  logic             brkHit,
  input  logic             waiHit,
  input  logic             stpHit,
  output logic             stackWr,
  output logic             spDec,
  output logic [1:0]       stackSel,
  output logic             pcSkip,
  output logic [ST_W-1:0]  statusOr,
  output logic             setI,
  output logic             clrD,
  output logic             vecRd,
  output logic [VEC_W-1:0] vecAddr,
  output logic             halt
);

  seqStrobe_t strobe;

  irqseq_ctrl #(.NMI_SYNC(NMI_SYNC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .nmiN     (nmiN),
    .irqN     (irqN),
    .iFlag    (iFlag),
    .boundary (boundary),
    .brkHit   (brkHit),
    .waiHit   (waiHit),
    .stpHit   (stpHit),
    .strobe   (strobe),
    .halt     (halt)
  );

  irqseq_dp #(
    .VEC_W   (VEC_W),
    .ST_W    (ST_W),
    .B_POS   (B_POS),
    .U_POS   (U_POS),
    .NMI_VEC (NMI_VEC),
    .RST_VEC (RST_VEC),
    .IRQ_VEC (IRQ_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stackWr  (stackWr),
    .spDec    (spDec),
    .stackSel (stackSel),
    .pcSkip   (pcSkip),
    .statusOr (statusOr),
    .setI     (setI),
    .clrD     (clrD),
    .vecRd    (vecRd),
    .vecAddr  (vecAddr)
  );

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rstN, nmiN, irqN, iFlag, boundary, brkHit, waiHit, stpHit;
  logic        stackWr, spDec, pcSkip, setI, clrD, vecRd, halt;
  logic [1:0]  stackSel;
  logic [7:0]  statusOr;
  logic [15:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .irqN(irqN), .iFlag(iFlag),
    .boundary(boundary), .brkHit(brkHit), .waiHit(waiHit), .stpHit(stpHit),
    .stackWr(stackWr), .spDec(spDec), .stackSel(stackSel), .pcSkip(pcSkip),
    .statusOr(statusOr), .setI(setI), .clrD(clrD), .vecRd(vecRd),
    .vecAddr(vecAddr), .halt(halt)
  );

  // source codes used by the bench: 0 reset, 1 nmi, 2 irq, 3 break, -1 none
  function automatic int vecBase(int s);
    if (s == 1) return 'hFFFA;
    if (s == 0) return 'hFFFC;
    return 'hFFFE;
  endfunction

  function automatic int predict(bit pend, bit irqLow, bit iF, bit brk);
    if (pend) return 1;
    if (irqLow && !iF) return 2;
    if (brk) return 3;
    return -1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse(bit b, bit w, bit st);
    @(negedge clk);
    boundary = 1'b1; brkHit = b; waiHit = w; stpHit = st;
    @(posedge clk);
    #1;
    boundary = 1'b0; brkHit = 1'b0; waiHit = 1'b0; stpHit = 1'b0;
  endtask

  task automatic expectIdle(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, "stackWr idle", stackWr, 0);
      check(tag, "spDec idle", spDec, 0);
      check(tag, "vecRd idle", vecRd, 0);
    end
  endtask

  task automatic runEntry(int s, bit noise, string tag);
    string seqTag;
    seqTag = (s == 0) ? "R1" : tag;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check(seqTag, "stackSel", stackSel, (k <= 3) ? k : 0);
      check(seqTag, "stackWr", stackWr, (k <= 3 && s != 0) ? 1 : 0);
      check(seqTag, "spDec", spDec, (k <= 3) ? 1 : 0);
      check("R4", "statusOr", statusOr, (k == 3) ? ((s == 3) ? 'h30 : 'h20) : 0);
      check("R5", "pcSkip", pcSkip, (k <= 2 && s == 3) ? 1 : 0);
      check(seqTag, "setI", setI, (k == 4) ? 1 : 0);
      check(seqTag, "clrD", clrD, (k == 4) ? 1 : 0);
      check(seqTag, "vecRd", vecRd, (k >= 5) ? 1 : 0);
      if (k >= 5) check("R3", "vecAddr", vecAddr, vecBase(s) + k - 5);
      if (noise) begin
        boundary = (k < 6);
        brkHit   = (k < 6);
      end
    end
    expectIdle(noise ? "R11" : seqTag, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    bit pend;
    void'($urandom(32'd5813));
    rstN = 1'b0; nmiN = 1'b1; irqN = 1'b1; iFlag = 1'b1;
    boundary = 1'b0; brkHit = 1'b0; waiHit = 1'b0; stpHit = 1'b0;
    pend = 1'b0;

    repeat (3) @(negedge clk);
    check("R1", "halt in reset", halt, 0);
    check("R1", "stackWr in reset", stackWr, 0);
    check("R1", "spDec in reset", spDec, 0);
    check("R1", "vecRd in reset", vecRd, 0);
    rstN = 1'b1;
    runEntry(0, 0, "R1");

    // break alone
    pulse(1, 0, 0);
    runEntry(3, 0, "R2");

    // masked level
    @(negedge clk); irqN = 1'b0; iFlag = 1'b1;
    pulse(0, 0, 0);
    expectIdle("R6", 3);

    // unmasked level
    @(negedge clk); iFlag = 1'b0;
    pulse(0, 0, 0);
    runEntry(2, 0, "R2");
    @(negedge clk); irqN = 1'b1; iFlag = 1'b1;

    // edge taken with iFlag set, held level does not repeat
    @(negedge clk); nmiN = 1'b0;
    pulse(0, 0, 0);
    runEntry(1, 0, "R7");
    pulse(0, 0, 0);
    expectIdle("R7", 2);
    @(negedge clk); nmiN = 1'b1;

    // all three together: nmi, then irq, then the break again
    @(negedge clk); nmiN = 1'b0; irqN = 1'b0; iFlag = 1'b0;
    pulse(1, 0, 0);
    runEntry(1, 0, "R8");
    pulse(1, 0, 0);
    runEntry(2, 0, "R8");
    @(negedge clk); irqN = 1'b1; nmiN = 1'b1; iFlag = 1'b1;
    pulse(1, 0, 0);
    runEntry(3, 0, "R8");

    // strobes during a running routine
    pulse(1, 0, 0);
    runEntry(3, 1, "R11");

    // wait with iFlag set resumes without entry
    pulse(0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", "halt while waiting", halt, 1);
    end
    irqN = 1'b0;
    @(negedge clk);
    check("R9", "halt after resume", halt, 0);
    check("R9", "no push on resume", stackWr, 0);
    expectIdle("R9", 2);
    irqN = 1'b1;

    // wait with iFlag clear takes the maskable vector
    @(negedge clk); iFlag = 1'b0;
    pulse(0, 1, 0);
    @(negedge clk);
    check("R9", "halt while waiting", halt, 1);
    irqN = 1'b0;
    runEntry(2, 0, "R9");
    @(negedge clk); irqN = 1'b1; iFlag = 1'b1;

    // wait woken by a non-maskable edge
    pulse(0, 1, 0);
    @(negedge clk);
    check("R9", "halt while waiting", halt, 1);
    nmiN = 1'b0;
    runEntry(1, 0, "R9");
    @(negedge clk); nmiN = 1'b1;

    // random mix
    for (int it = 0; it < 150; it++) begin
      bit b;
      int s;
      @(negedge clk);
      iFlag = 1'($urandom % 2);
      irqN  = 1'($urandom % 2);
      b     = ($urandom % 3) == 0;
      if (($urandom % 3) == 0) begin
        if (nmiN) begin
          nmiN = 1'b0;
          pend = 1'b1;
        end else begin
          nmiN = 1'b1;
        end
      end
      s = predict(pend, !irqN, iFlag, b);
      pulse(b, 0, 0);
      if (s >= 0) runEntry(s, 0, "R8");
      else expectIdle("R6", 1);
      if (s == 1) pend = 1'b0;
    end

    // stop ignores everything until reset
    @(negedge clk); irqN = 1'b1; nmiN = 1'b1; iFlag = 1'b1;
    pulse(0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10", "halt in stop", halt, 1);
      check("R10", "no push in stop", stackWr, 0);
      check("R10", "no vector in stop", vecRd, 0);
      nmiN = ~nmiN; irqN = 1'b0; iFlag = 1'b0; boundary = 1'b1; brkHit = 1'b1;
    end
    boundary = 1'b0; brkHit = 1'b0; irqN = 1'b1; nmiN = 1'b1; iFlag = 1'b1;
    @(negedge clk);
    check("R10", "still halted", halt, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R10", "halt cleared by reset", halt, 0);
    rstN = 1'b1;
    runEntry(0, 0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule